// File: doc/BRIEF.md
# Program Counter and Branch Unit

This block holds the 16-bit program counter of a small load-store processor and works out the address of the next instruction to fetch. Each time the controller pulses the step strobe, the unit retires the instruction word it is given. It looks at that word together with the value of the register the word selects, and then moves the counter. The move is a sequential advance, a conditional relative branch on zero or nonzero, a register-indirect jump, or entry into a halted state.

The counter is moved past the current instruction before that instruction acts. Relative branch targets are therefore measured from the following instruction. Every offset is the low byte of the word, sign-extended and doubled, so targets stay on even addresses. A single reserved instruction word stops the unit for good. Only the synchronous reset clears that state.

Top module: `pcu_top`

## Requirements
- R1: On a rising clock edge with `rst` high, `pc` becomes 0x0000 and `halted` becomes 0, whatever the step strobe, the word or the earlier halt state.
- R2: On an edge with `rst` low and `step` low, `pc` and `halted` keep their values.
- R3: A retired word that is not a branch, jump or halt sets `pc` to `pc + 2`, wrapping modulo 2^16 (0xFFFE goes to 0x0000).
- R4: A word with bits 15:12 equal to 0xC branches when `rsel` is 0x0000, setting `pc` to `pc + 2 + off`. Otherwise it advances `pc` by 2. Here `off` is bits 7:0 sign-extended to 16 bits and shifted left by one.
- R5: A word with bits 15:12 equal to 0xD branches to `pc + 2 + off` when `rsel` is nonzero, and advances `pc` by 2 when `rsel` is zero.
- R6: Byte values 0x80 to 0xFF in bits 7:0 give negative offsets, from -256 to -2. Sums wrap modulo 2^16.
- R7: A word with bits 15:12 equal to 0xF sets `pc` to `rsel + off` with bit 0 forced to 0, whatever value `rsel` holds.
- R8: The exact word 0x7FFF advances `pc` by 2 and sets `halted`. After that, no step changes `pc` or `halted` until reset.
- R9: Words with bits 15:12 equal to 0x7 other than 0x7FFF, and all other opcodes except 0xC, 0xD and 0xF, only advance `pc` by 2.
- R10: Bit 0 of `pc` is 0 at every edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Retire the presented instruction on this edge |
| instr | input | 16 | Instruction word being retired |
| rsel | input | 16 | Value of the register named by instruction bits 11:8 |
| pc | output | 16 | Current program counter |
| halted | output | 1 | High once the halt word has retired, until reset |

## Verification
The bench checks branch targets against the counter already advanced by two. A design that measured from the branch itself would land two bytes short. Offsets with the top bit set are used to catch a zero-extended offset, which would jump far forward instead of back. It also covers a jump from an odd register value and an advance out of 0xFFFE, which catch a missing bit-0 mask and a carry leaking past 16 bits. Near-miss opcode-7 words must only advance, and steps after a halt must leave the counter untouched. This catches a design that halts on any opcode-7 word or forgets the sticky state.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int PC_W  = 16;
  localparam int INS_W = 16;
  localparam int OP_W  = 4;
  localparam int IMM_W = 8;
  localparam int STEP_BYTES = 2;

  localparam logic [OP_W-1:0]  OP_BZ   = 4'hC;
  localparam logic [OP_W-1:0]  OP_BNZ  = 4'hD;
  localparam logic [OP_W-1:0]  OP_JMP  = 4'hF;
  localparam logic [INS_W-1:0] HALT_WORD = 16'h7FFF;

  typedef enum logic [2:0] {
    K_SEQ  = 3'd0,
    K_BZ   = 3'd1,
    K_BNZ  = 3'd2,
    K_JUMP = 3'd3,
    K_HALT = 3'd4
  } kind_t;

  // sign-extend an immediate byte and double it
  function automatic logic [PC_W-1:0] scaled_offset(input logic [IMM_W-1:0] imm);
    logic [PC_W-1:0] ext;
    ext = {{(PC_W-IMM_W){imm[IMM_W-1]}}, imm};
    return {ext[PC_W-2:0], 1'b0};
  endfunction

  // modular address sum
  function automatic logic [PC_W-1:0] addr_add(input logic [PC_W-1:0] a,
                                               input logic [PC_W-1:0] b);
    return a + b;
  endfunction

  // clear the byte-select bit of an address
  function automatic logic [PC_W-1:0] align_even(input logic [PC_W-1:0] a);
    return {a[PC_W-1:1], 1'b0};
  endfunction
endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
  import pcu_pkg::*;
#(
  parameter int IW = INS_W,
  parameter int AW = PC_W
) (
  input  logic [IW-1:0] instr,
  output kind_t         kind,
  output logic [AW-1:0] offs
);
  localparam int OPW = OP_W;
  localparam int IMW = IMM_W;

  logic [OPW-1:0] opc;
  logic           is_halt;

  assign opc     = instr[IW-1 -: OPW];
  assign is_halt = (instr == HALT_WORD);
  assign offs    = scaled_offset(instr[IMW-1:0]);

  always_comb begin
    if (is_halt)              kind = K_HALT;
    else if (opc == OP_BZ)    kind = K_BZ;
    else if (opc == OP_BNZ)   kind = K_BNZ;
    else if (opc == OP_JMP)   kind = K_JUMP;
    else                      kind = K_SEQ;
  end
endmodule

// File: rtl/pcu_target.sv
module pcu_target
  import pcu_pkg::*;
#(
  parameter int AW = PC_W
) (
  input  logic [AW-1:0] pc,
  input  kind_t         kind,
  input  logic [AW-1:0] offs,
  input  logic [AW-1:0] rsel,
  output logic [AW-1:0] next_pc
);
  localparam logic [AW-1:0] INC = AW'(STEP_BYTES);

  logic [AW-1:0] seq_pc;
  logic [AW-1:0] rel_pc;
  logic [AW-1:0] abs_pc;
  logic          reg_zero;

  assign seq_pc   = addr_add(pc, INC);
  assign rel_pc   = addr_add(seq_pc, offs);
  assign abs_pc   = align_even(addr_add(rsel, offs));
  assign reg_zero = (rsel == '0);

  always_comb begin
    unique case (kind)
      K_BZ:    next_pc = reg_zero  ? rel_pc : seq_pc;
      K_BNZ:   next_pc = !reg_zero ? rel_pc : seq_pc;
      K_JUMP:  next_pc = abs_pc;
      default: next_pc = seq_pc;
    endcase
  end
endmodule

// File: rtl/pcu_state.sv
module pcu_state #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          halt_req,
  input  logic [AW-1:0] next_pc,
  output logic [AW-1:0] pc,
  output logic          halted,
  output logic          retire
);
  assign retire = step && !halted;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      halted <= 1'b0;
    end else if (retire) begin
      pc     <= next_pc;
      halted <= halt_req;
    end
  end
endmodule

// File: rtl/pcu_top.sv
module pcu_top
  import pcu_pkg::*;
#(
  parameter int AW = PC_W,
  parameter int IW = INS_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [IW-1:0] instr,
  input  logic [AW-1:0] rsel,
  output logic [AW-1:0] pc,
  output logic          halted
);
  kind_t         kind_w;
  logic [AW-1:0] offs_w;
  logic [AW-1:0] next_w;
  logic          retire_w;
  logic          halt_req_w;

  assign halt_req_w = (kind_w == K_HALT);

  pcu_decode #(.IW(IW), .AW(AW)) u_dec (
    .instr (instr),
    .kind  (kind_w),
    .offs  (offs_w)
  );

  pcu_target #(.AW(AW)) u_tgt (
    .pc      (pc),
    .kind    (kind_w),
    .offs    (offs_w),
    .rsel    (rsel),
    .next_pc (next_w)
  );

  pcu_state #(.AW(AW)) u_st (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .halt_req (halt_req_w),
    .next_pc  (next_w),
    .pc       (pc),
    .halted   (halted),
    .retire   (retire_w)
  );
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker
  import pcu_pkg::*;
#(
  parameter int AW = PC_W
) (
  input logic          clk,
  input logic          rst,
  input logic          step,
  input logic [AW-1:0] pc,
  input logic          halted,
  input kind_t         kind,
  input logic          fire
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pc == '0 && !halted));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(pc) && $stable(halted)));

  a_r3_seq_advance: assert property (@(posedge clk) disable iff (rst)
    (fire && kind == K_SEQ) |=> (pc == AW'($past(pc) + AW'(STEP_BYTES))));

  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc)));

  a_r8_halt_entry: assert property (@(posedge clk) disable iff (rst)
    (fire && kind == K_HALT) |=> halted);

  a_r10_even_pc: assert property (@(posedge clk) disable iff (rst)
    !pc[0]);
endmodule

bind pcu_top pcu_checker #(.AW(AW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .step   (step),
  .pc     (pc),
  .halted (halted),
  .kind   (kind_w),
  .fire   (retire_w)
);

// File: tb/pcu_top_bench.sv
module pcu_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        step;
  logic [15:0] instr;
  logic [15:0] rsel;
  logic [15:0] pc;
  logic        halted;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] exp_pc;
  logic        exp_halt;

  pcu_top u_pcu_top (
    .clk(clk), .rst(rst), .step(step), .instr(instr),
    .rsel(rsel), .pc(pc), .halted(halted)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk({req, " pc"}, pc, exp_pc);
    chk({req, " halted"}, {15'd0, halted}, {15'd0, exp_halt});
  endtask

  // bench's own restatement of the next-address rule
  function automatic logic [15:0] model(input logic [15:0] cur, input logic [15:0] w,
                                        input logic [15:0] r);
    int off, seq;
    off = int'($signed(w[7:0])) * 2;
    seq = (int'(cur) + 2) & 16'hFFFF;
    case (w[15:12])
      4'hC: return (r == 0) ? 16'((seq + off) & 16'hFFFF) : 16'(seq);
      4'hD: return (r != 0) ? 16'((seq + off) & 16'hFFFF) : 16'(seq);
      4'hF: return 16'((int'(r) + off) & 16'hFFFE);
      default: return 16'(seq);
    endcase
  endfunction

  task automatic exec(input logic [15:0] w, input logic [15:0] r);
    @(negedge clk);
    instr = w; rsel = r; step = 1'b1;
    if (!exp_halt) begin
      exp_pc = model(exp_pc, w, r);
      if (w == 16'h7FFF) exp_halt = 1'b1;
    end
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic do_reset(input string req);
    @(negedge clk);
    rst = 1'b1; step = 1'b1; instr = 16'hF000; rsel = 16'h1234;
    @(negedge clk);
    rst = 1'b0; step = 1'b0;
    exp_pc = 16'h0000; exp_halt = 1'b0;
    chk_state(req);
  endtask

  task automatic goto(input logic [15:0] a);
    exec(16'hF000, a);
  endtask

  task automatic t_reset();
    do_reset("R1 reset");
  endtask

  task automatic t_idle();
    goto(16'h0100);
    chk_state("R7 jump base");
    repeat (3) @(negedge clk);
    instr = 16'hF0FF; rsel = 16'h4444;
    repeat (2) @(negedge clk);
    chk_state("R2 idle hold");
  endtask

  task automatic t_seq();
    exec(16'h0123, 16'h0000);
    chk_state("R3 add advance");
    goto(16'hFFFE);
    exec(16'h8400, 16'h0000);
    chk_state("R3 wrap to zero");
    chk("R10 even after wrap", {15'd0, pc[0]}, 16'h0000);
  endtask

  task automatic t_bz();
    goto(16'h0200);
    exec(16'hC310, 16'h0000);
    chk_state("R4 bz taken");
    chk("R4 bz target", pc, 16'h0222);
    exec(16'hC310, 16'h0001);
    chk_state("R4 bz not taken");
  endtask

  task automatic t_bnz();
    goto(16'h0300);
    exec(16'hD105, 16'h8000);
    chk_state("R5 bnz taken");
    chk("R5 bnz target", pc, 16'h030C);
    exec(16'hD105, 16'h0000);
    chk_state("R5 bnz not taken");
  endtask

  task automatic t_neg();
    goto(16'h0400);
    exec(16'hC2FF, 16'h0000);
    chk("R6 minus one word", pc, 16'h0400);
    exec(16'hD280, 16'h0007);
    chk("R6 most negative", pc, 16'h0302);
    goto(16'h0010);
    exec(16'hC280, 16'h0000);
    chk_state("R6 wrap below zero");
  endtask

  task automatic t_jump();
    exec(16'hF305, 16'h1233);
    chk_state("R7 odd reg masked");
    chk("R10 jump even", {15'd0, pc[0]}, 16'h0000);
    exec(16'hF3FE, 16'h0002);
    chk("R7 jump negative", pc, 16'hFFFE);
  endtask

  task automatic t_op7();
    goto(16'h0500);
    exec(16'h7FFE, 16'h0000);
    chk_state("R9 near halt word");
    exec(16'h7EFF, 16'h0000);
    chk_state("R9 opcode7 other");
    exec(16'hA0FF, 16'h0000);
    chk_state("R9 const only advances");
  endtask

  task automatic t_halt();
    goto(16'h0600);
    exec(16'h7FFF, 16'h0000);
    chk_state("R8 halt entry");
    chk("R8 halt pc", pc, 16'h0602);
    exec(16'hF000, 16'h2000);
    exec(16'hC010, 16'h0000);
    exec(16'h0000, 16'h0000);
    chk_state("R8 sticky after steps");
    do_reset("R1 reset clears halt");
    exec(16'h0000, 16'h0000);
    chk("R1 runs after reset", pc, 16'h0002);
  endtask

  initial begin
    rst = 1'b1; step = 1'b0; instr = 16'h0000; rsel = 16'h0000;
    exp_pc = 16'h0000; exp_halt = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_idle();
    t_seq();
    t_bz();
    t_bnz();
    t_neg();
    t_jump();
    t_op7();
    t_halt();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule